// File: doc/BRIEF.md
# Packet Header ECC Checker and Corrector

This block sits behind the lane-merging logic of a camera serial receiver. It looks at each 32-bit packet header once. The header carries a data identifier byte, a 16-bit field and an 8-bit check byte. The 16-bit field is the payload length for long packets and the data value for short packets. The block recomputes six parity bits over the 24 protected bits using a Hamming SEC-DED code. It forms a syndrome against the received check byte. From the syndrome it either passes the header through, repairs a single flipped bit, or marks the header as damaged beyond repair.

The checked header comes out one cycle after it is accepted. Alongside it the block gives a long/short decision and the payload byte count, so the payload stage that follows can collect exactly that many bytes. It does no sync search inside the payload. Every repair and every uncorrectable header sets a sticky status bit for the header's virtual channel. Software clears these bits by writing ones. Per-bit enables decide which status bits raise the interrupt line. These enables never stop a status bit from being set. A global enable input can switch the whole check off.

Top module: `hdr_ecc_guard`

## Requirements
- R1: After reset, out_valid, out_corrected, out_uncorrectable, out_is_long, out_hdr, out_word_count, both status vectors and irq are all zero.
- R2: Header layout: bits 7:0 are the data identifier, bits 23:8 are the 16-bit field, and bits 31:24 are the check byte. Check-byte bits 5:0 are the parity and bits 7:6 must be zero. A header accepted with in_valid appears on the outputs in the following cycle, with out_valid high. A header whose syndrome is zero comes out unchanged, with neither flag set.
- R3: If exactly one of bits 23:0 is flipped, that bit is restored. The output header then equals the error-free header, and out_corrected is high.
- R4: If exactly one of bits 31:24 is flipped (including bits 31 and 30), the output check byte is restored to the correct value and out_corrected is high.
- R5: If two bits are flipped anywhere in the header, the output header equals the received one and out_uncorrectable is high. out_corrected is never high together with out_uncorrectable.
- R6: The virtual channel is bits 7:6 of the header. It selects which status bit is set. A repaired header uses the repaired value. An uncorrectable header uses the raw received value.
- R7: Status bits are sticky. A 1 on clr_corr[i] or clr_uncorr[i] clears bit i. If a new event for bit i arrives in the same cycle as its clear, the bit stays set.
- R8: irq is high exactly when some status bit is set and its enable bit is also set. A clear enable bit never prevents the status bit from being set.
- R9: While ecc_en is 0, headers pass through unchanged, neither flag is set, and no status bit changes.
- R10: A header is long when its data type (bits 5:0 of the output header) is 0x10 or above. out_is_long then goes high and out_word_count carries bits 23:8. For short headers, out_word_count is zero.
- R11: In a cycle with in_valid low, no output appears in the next cycle and the status bits keep their values apart from clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ecc_en | input | 1 | 1 enables checking, 0 passes headers through |
| in_valid | input | 1 | in_hdr holds a header this cycle |
| in_hdr | input | 32 | Received packet header |
| clr_corr | input | 4 | Write-one-to-clear for the corrected status bits |
| clr_uncorr | input | 4 | Write-one-to-clear for the uncorrectable status bits |
| irq_en_corr | input | 4 | Interrupt enable for each corrected status bit |
| irq_en_uncorr | input | 4 | Interrupt enable for each uncorrectable status bit |
| out_valid | output | 1 | Output header is valid |
| out_hdr | output | 32 | Checked (and possibly repaired) header |
| out_corrected | output | 1 | A single-bit error was repaired |
| out_uncorrectable | output | 1 | The error could not be repaired |
| out_is_long | output | 1 | The header starts a long packet |
| out_word_count | output | 16 | Payload byte count for long packets, else zero |
| stat_corr | output | 4 | Sticky corrected-event bits, one per virtual channel |
| stat_uncorr | output | 4 | Sticky uncorrectable-event bits, one per virtual channel |
| irq | output | 1 | Interrupt request |

## Verification
A new ECC event and a software clear of the same status bit can fall in the same cycle. The bench provokes this by driving a header with one flipped bit for virtual channel 2 in the same cycle that clr_corr[2] is asserted. It then expects the bit to read back as set. A clear with no event in that cycle is checked separately and must empty the bit. Header results are judged by a scoreboard that predicts each output from the number of bits the bench flipped, not from any syndrome.

// File: rtl/hdr_ecc_pkg.sv
package hdr_ecc_pkg;

    localparam int DATA_W     = 24;
    localparam int PAR_W      = 6;
    localparam int CHK_W      = 8;
    localparam int HDR_W      = DATA_W + CHK_W;
    localparam int FIELD_W    = 16;
    localparam int FIELD_LSB  = 8;
    localparam int DT_W       = 6;
    localparam int NUM_VC     = 4;
    localparam int VC_W       = $clog2(NUM_VC);
    localparam int VC_MSB     = 7;
    localparam logic [DT_W-1:0] SHORT_DT_LAST = 6'h0F;

    typedef enum logic [1:0] {
        ECC_CLEAN      = 2'd0,
        ECC_FIX_DATA   = 2'd1,
        ECC_FIX_PARITY = 2'd2,
        ECC_BROKEN     = 2'd3
    } ecc_cls_e;

    typedef struct packed {
        logic               vld;
        logic [HDR_W-1:0]   hdr;
        logic               corr;
        logic               unc;
        logic               lng;
        logic [FIELD_W-1:0] wc;
    } hdr_out_s;

    // Parity-bit membership of each protected bit (bit p set: bit feeds parity p)
    function automatic logic [PAR_W-1:0] col_code(input int unsigned idx);
        logic [PAR_W-1:0] c;
        case (idx)
            0:  c = 6'h07;  1:  c = 6'h0B;  2:  c = 6'h0D;  3:  c = 6'h0E;
            4:  c = 6'h13;  5:  c = 6'h15;  6:  c = 6'h16;  7:  c = 6'h19;
            8:  c = 6'h1A;  9:  c = 6'h1C;  10: c = 6'h23;  11: c = 6'h25;
            12: c = 6'h26;  13: c = 6'h29;  14: c = 6'h2A;  15: c = 6'h2C;
            16: c = 6'h31;  17: c = 6'h32;  18: c = 6'h34;  19: c = 6'h38;
            20: c = 6'h1F;  21: c = 6'h2F;  22: c = 6'h37;  23: c = 6'h3B;
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/hdr_ecc_gen.sv
module hdr_ecc_gen
    import hdr_ecc_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [PAR_W-1:0]  par_o
);
    always_comb begin
        par_o = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (data_i[i]) par_o = par_o ^ col_code(i);
        end
    end
endmodule

// File: rtl/hdr_ecc_syndrome.sv
module hdr_ecc_syndrome
    import hdr_ecc_pkg::*;
(
    input  logic [HDR_W-1:0] hdr_i,
    output logic [HDR_W-1:0] fixed_o,
    output ecc_cls_e         cls_o
);
    logic [PAR_W-1:0]  par;
    logic [CHK_W-1:0]  syn;
    logic [DATA_W-1:0] hit;

    hdr_ecc_gen i_gen (
        .data_i (hdr_i[DATA_W-1:0]),
        .par_o  (par)
    );

    assign syn = hdr_i[HDR_W-1:DATA_W] ^ {{(CHK_W-PAR_W){1'b0}}, par};

    // One comparator per protected bit: a match names the flipped bit
    for (genvar g = 0; g < DATA_W; g++) begin : g_col
        assign hit[g] = (syn == {{(CHK_W-PAR_W){1'b0}}, col_code(g)});
    end

    always_comb begin
        fixed_o = hdr_i;
        cls_o   = ECC_CLEAN;
        if (syn == '0) begin
            cls_o = ECC_CLEAN;
        end else if (|hit) begin
            cls_o                 = ECC_FIX_DATA;
            fixed_o[DATA_W-1:0]   = hdr_i[DATA_W-1:0] ^ hit;
        end else if ($countones(syn) == 1) begin
            cls_o                   = ECC_FIX_PARITY;
            fixed_o[HDR_W-1:DATA_W] = {{(CHK_W-PAR_W){1'b0}}, par};
        end else begin
            cls_o = ECC_BROKEN;
        end
    end
endmodule

// File: rtl/hdr_ecc_log.sv
module hdr_ecc_log
    import hdr_ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_VC-1:0] set_corr_i,
    input  logic [NUM_VC-1:0] set_unc_i,
    input  logic [NUM_VC-1:0] clr_corr_i,
    input  logic [NUM_VC-1:0] clr_unc_i,
    input  logic [NUM_VC-1:0] en_corr_i,
    input  logic [NUM_VC-1:0] en_unc_i,
    output logic [NUM_VC-1:0] st_corr_o,
    output logic [NUM_VC-1:0] st_unc_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [NUM_VC-1:0] corr;
        logic [NUM_VC-1:0] unc;
    } log_s;

    log_s log_d, log_q;

    always_comb begin
        log_d      = log_q;
        log_d.corr = (log_q.corr & ~clr_corr_i) | set_corr_i;
        log_d.unc  = (log_q.unc  & ~clr_unc_i)  | set_unc_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) log_q <= '0;
        else        log_q <= log_d;
    end

    assign st_corr_o = log_q.corr;
    assign st_unc_o  = log_q.unc;
    assign irq_o     = |((log_q.corr & en_corr_i) | (log_q.unc & en_unc_i));

    AST_STICKY_CORR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(log_q.corr & ~clr_corr_i) & ~log_q.corr) == '0)); // R7
    AST_STICKY_UNC: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(log_q.unc & ~clr_unc_i) & ~log_q.unc) == '0)); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(set_corr_i) & ~log_q.corr) | ($past(set_unc_i) & ~log_q.unc)) == '0)); // R7
endmodule

// File: rtl/hdr_ecc_guard.sv
module hdr_ecc_guard
    import hdr_ecc_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ecc_en,
    input  logic         in_valid,
    input  logic [31:0]  in_hdr,
    input  logic [3:0]   clr_corr,
    input  logic [3:0]   clr_uncorr,
    input  logic [3:0]   irq_en_corr,
    input  logic [3:0]   irq_en_uncorr,
    output logic         out_valid,
    output logic [31:0]  out_hdr,
    output logic         out_corrected,
    output logic         out_uncorrectable,
    output logic         out_is_long,
    output logic [15:0]  out_word_count,
    output logic [3:0]   stat_corr,
    output logic [3:0]   stat_uncorr,
    output logic         irq
);
    logic [HDR_W-1:0]  fixed_hdr;
    ecc_cls_e          cls;
    logic [NUM_VC-1:0] set_corr, set_unc;
    hdr_out_s          out_d, out_q;

    hdr_ecc_syndrome i_syn (
        .hdr_i   (in_hdr),
        .fixed_o (fixed_hdr),
        .cls_o   (cls)
    );

    always_comb begin
        out_d    = '0;
        set_corr = '0;
        set_unc  = '0;
        if (in_valid) begin
            out_d.vld = 1'b1;
            out_d.hdr = in_hdr;
            if (ecc_en) begin
                case (cls)
                    ECC_FIX_DATA, ECC_FIX_PARITY: begin
                        out_d.hdr  = fixed_hdr;
                        out_d.corr = 1'b1;
                        set_corr[fixed_hdr[VC_MSB -: VC_W]] = 1'b1;
                    end
                    ECC_BROKEN: begin
                        out_d.unc = 1'b1;
                        set_unc[in_hdr[VC_MSB -: VC_W]] = 1'b1;
                    end
                    default: ;
                endcase
            end
            out_d.lng = (out_d.hdr[DT_W-1:0] > SHORT_DT_LAST);
            out_d.wc  = out_d.lng ? out_d.hdr[FIELD_LSB +: FIELD_W] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    hdr_ecc_log i_log (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_corr_i (set_corr),
        .set_unc_i  (set_unc),
        .clr_corr_i (clr_corr),
        .clr_unc_i  (clr_uncorr),
        .en_corr_i  (irq_en_corr),
        .en_unc_i   (irq_en_uncorr),
        .st_corr_o  (stat_corr),
        .st_unc_o   (stat_uncorr),
        .irq_o      (irq)
    );

    assign out_valid         = out_q.vld;
    assign out_hdr           = out_q.hdr;
    assign out_corrected     = out_q.corr;
    assign out_uncorrectable = out_q.unc;
    assign out_is_long       = out_q.lng;
    assign out_word_count    = out_q.wc;

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R11
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_corrected && out_uncorrectable)); // R5
    AST_CORR_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_corrected) |-> stat_corr[out_hdr[7:6]]); // R6
    AST_UNC_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_uncorrectable) |-> stat_uncorr[out_hdr[7:6]]); // R6
    AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ecc_en) |=> (!out_corrected && !out_uncorrectable
                                   && out_hdr == $past(in_hdr))); // R9
    AST_IRQ_UNC: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_uncorrectable && irq_en_uncorr[out_hdr[7:6]]) |-> irq); // R8
endmodule

// File: tb/test_hdr_ecc_guard.sv
module test_hdr_ecc_guard;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ecc_en = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_hdr = '0;
    logic [3:0]  clr_corr = '0, clr_uncorr = '0, irq_en_corr = '0, irq_en_uncorr = '0;
    logic        out_valid, out_corrected, out_uncorrectable, out_is_long, irq;
    logic [31:0] out_hdr;
    logic [15:0] out_word_count;
    logic [3:0]  stat_corr, stat_uncorr;

    hdr_ecc_guard i_hdr_ecc_guard (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [31:0] hdr;
        logic        corr;
        logic        unc;
        logic        lng;
        logic [15:0] wc;
        string       req;
    } exp_t;

    exp_t        sb[$];
    int          n_checks = 0, n_fail = 0, cycles = 0;
    bit          done = 0;
    logic [3:0]  m_corr = '0, m_unc = '0;

    function automatic logic [7:0] tb_ecc(input logic [23:0] d);
        logic [7:0] p;
        p[0] = d[0]^d[1]^d[2]^d[4]^d[5]^d[7]^d[10]^d[11]^d[13]^d[16]^d[20]^d[21]^d[22]^d[23];
        p[1] = d[0]^d[1]^d[3]^d[4]^d[6]^d[8]^d[10]^d[12]^d[14]^d[17]^d[20]^d[21]^d[22]^d[23];
        p[2] = d[0]^d[2]^d[3]^d[5]^d[6]^d[9]^d[11]^d[12]^d[15]^d[18]^d[20]^d[21]^d[22];
        p[3] = d[1]^d[2]^d[3]^d[7]^d[8]^d[9]^d[13]^d[14]^d[15]^d[19]^d[20]^d[21]^d[23];
        p[4] = d[4]^d[5]^d[6]^d[7]^d[8]^d[9]^d[16]^d[17]^d[18]^d[19]^d[20]^d[22]^d[23];
        p[5] = d[10]^d[11]^d[12]^d[13]^d[14]^d[15]^d[16]^d[17]^d[18]^d[19]^d[21]^d[22]^d[23];
        p[7:6] = 2'b00;
        return p;
    endfunction

    function automatic logic [31:0] mk(input logic [7:0] di, input logic [15:0] fld);
        return {tb_ecc({fld, di}), fld, di};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("[TB] FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: predicts from the number of flipped bits, then pushes
    task automatic send(input logic [31:0] clean, input logic [31:0] flips, input string req,
                        input logic [3:0] clr_c = '0);
        exp_t e;
        logic [31:0] raw;
        int nf;
        raw = clean ^ flips;
        nf  = $countones(flips);
        e.corr = 0; e.unc = 0; e.req = req;
        if (!ecc_en)       e.hdr = raw;
        else if (nf == 0)  e.hdr = clean;
        else if (nf == 1) begin e.hdr = clean; e.corr = 1; end
        else begin e.hdr = raw; e.unc = 1; end
        e.lng = (e.hdr[5:0] >= 6'h10);
        e.wc  = e.lng ? e.hdr[23:8] : 16'h0;
        @(negedge clk);
        in_valid = 1; in_hdr = raw; clr_corr = clr_c;
        m_corr = m_corr & ~clr_c;
        if (e.corr) m_corr[clean[7:6]] = 1'b1;
        if (e.unc)  m_unc[raw[7:6]]    = 1'b1;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0; in_hdr = 32'hDEAD_BEEF; clr_corr = '0; clr_uncorr = '0;
        end
    endtask

    task automatic chk_status(input string req);
        check(stat_corr == m_corr && stat_uncorr == m_unc, req,
              {56'h0, stat_corr, stat_uncorr}, {56'h0, m_corr, m_unc});
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (sb.size() == 0) begin
                check(0, "R11 unexpected output", {32'h0, out_hdr}, 64'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(out_hdr == e.hdr && out_corrected == e.corr && out_uncorrectable == e.unc
                      && out_is_long == e.lng && out_word_count == e.wc, e.req,
                      {out_hdr, out_corrected, out_uncorrectable, out_is_long, 13'h0, out_word_count},
                      {e.hdr, e.corr, e.unc, e.lng, 13'h0, e.wc});
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            check(0, "watchdog", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        check({out_valid, out_corrected, out_uncorrectable, out_is_long, irq} == '0
              && out_hdr == '0 && out_word_count == '0 && stat_corr == '0 && stat_uncorr == '0,
              "R1 reset state", {31'h0, out_valid, out_hdr}, 64'h0);

        // R2 / R10 clean headers
        send(mk(8'h01, 16'hA5C3), 32'h0, "R2 clean short");
        send(mk(8'h6A, 16'h0123), 32'h0, "R10 clean long vc1");
        send(mk(8'hCF, 16'hFFFF), 32'h0, "R10 short dt 0x0F");
        send(mk(8'h10, 16'h0040), 32'h0, "R10 long dt 0x10");
        idle(2);
        chk_status("R2 no events on clean");

        // R3 single data-bit errors
        send(mk(8'h2B, 16'h0800), 32'h0000_0001, "R3 flip bit0");
        send(mk(8'h2B, 16'h1234), 32'h0000_1000, "R3 flip bit12");
        send(mk(8'h12, 16'h5678), 32'h0080_0000, "R3 flip bit23");
        send(mk(8'hE4, 16'h0002), 32'h0000_0040, "R6 flip vc bit6");
        idle(2);
        chk_status("R6 corrected vc from repaired id");

        // R4 single parity-bit errors
        send(mk(8'h40, 16'h00FF), 32'h0100_0000, "R4 flip bit24");
        send(mk(8'h80, 16'h0F0F), 32'h2000_0000, "R4 flip bit29");
        send(mk(8'h80, 16'h0F0F), 32'h8000_0000, "R4 flip bit31");
        idle(2);
        chk_status("R4 parity fixes logged");

        // R5 double errors
        send(mk(8'h2C, 16'h0010), 32'h0000_0081, "R5 two data bits vc raw");
        send(mk(8'h00, 16'h3333), 32'h0300_0000, "R5 two parity bits");
        send(mk(8'h51, 16'h9999), 32'h0100_0100, "R5 data and parity");
        idle(2);
        chk_status("R6 uncorrectable vc from raw id");

        // R8 interrupt masking
        irq_en_corr = '0; irq_en_uncorr = '0;
        @(negedge clk);
        check(irq == 0 && stat_corr != 0, "R8 masked irq low, logging kept",
              {63'h0, irq}, 64'h0);
        irq_en_corr = ~m_corr; irq_en_uncorr = ~m_unc;
        @(negedge clk);
        check(irq == 0, "R8 enable on clear bits", {63'h0, irq}, 64'h0);
        irq_en_uncorr = m_unc;
        @(negedge clk);
        check(irq == (m_unc != 0), "R8 enable on set bit", {63'h0, irq}, {63'h0, m_unc != 0});

        // R7 W1C, then set-vs-clear collision
        @(negedge clk);
        clr_corr = 4'b1111; clr_uncorr = 4'b1111;
        @(negedge clk);
        clr_corr = '0; clr_uncorr = '0;
        m_corr = '0; m_unc = '0;
        chk_status("R7 write-one clears all");
        check(irq == 0, "R8 irq drops after clear", {63'h0, irq}, 64'h0);
        send(mk(8'h85, 16'h0001), 32'h0000_0400, "R7 set vc2");
        idle(1);
        chk_status("R7 vc2 set");
        send(mk(8'h85, 16'h0002), 32'h0000_0002, "R7 collision", 4'b0100);
        idle(1);
        chk_status("R7 set wins over clear");
        clr_corr = 4'b0100;
        @(negedge clk);
        clr_corr = '0; m_corr[2] = 0;
        chk_status("R7 clear without event");
        irq_en_corr = '0; irq_en_uncorr = '0;

        // R9 check disabled
        ecc_en = 0;
        send(mk(8'h47, 16'h1111), 32'h0000_0008, "R9 bypass single flip");
        send(mk(8'hC0, 16'h2222), 32'h0000_0300, "R9 bypass double flip");
        send(mk(8'h30, 16'h0100), 32'h4000_0000, "R9 bypass parity flip long");
        idle(2);
        chk_status("R9 no logging while disabled");
        ecc_en = 1;

        // R11 idle cycles
        idle(6);
        chk_status("R11 status held while idle");
        check(sb.size() == 0, "R11 scoreboard drained", sb.size(), 0);
        finish_run();
    end
endmodule